// File: doc/BRIEF.md
# Preloaded PWM Burst Generator

This block is a single PWM channel that encodes bits as pulses of different widths. A free-running up-counter runs from zero to a reload limit and then returns to zero. Each such run is one period. The output is high at the start of each period for as many cycles as the active compare word gives. After that it stays low until the wrap.

A host writes the compare word and the reload limit. With the compare preload mode on, the compare write goes to a shadow register. The shadow value reaches the active register only at the update event, so a period is never changed once it has started. Each update event also raises a one-cycle request. An external feeder answers that request by writing the next compare word, which gives exactly one word per period.

A burst ends with one compare word of zero. That word keeps the line low while the counter goes on running, until software supplies the next burst or drops the enable.

Top module: `pwm_burst_gen`

## Requirements
- R1: While enabled, the counter steps by one per clock from 0 up to the active reload value and then returns to 0, so a period lasts (reload + 1) cycles.
- R2: The output is high while the counter is strictly below the active compare value and low otherwise. Each period therefore starts with min(compare, reload + 1) high cycles, followed only by low cycles.
- R3: With `cmp_preload` = 1, a compare write changes only the shadow register. The output of the current period is unaffected, and the new value applies from the next update event.
- R4: Several compare writes to the shadow within one period keep only the last one. That last value sets the width of the next period.
- R5: With `cmp_preload` = 0, a compare write reaches the active register at the same clock edge. The output in the following cycle already uses the new value.
- R6: `data_req` is high for exactly one cycle, which is the first cycle of every period (counter = 0). It never rises from a compare match.
- R7: A compare value of 0 keeps the output low for the whole period. A trailing zero word keeps the line low for every following period while the counter runs.
- R8: A compare value greater than the reload value keeps the output high for the whole period.
- R9: The reload value is also preloaded. A reload write during a period changes the length of the next period only.
- R10: While `enable` = 0, the counter is held at 0, the output is low and no request is raised, whatever the writes.
- R11: At the first enabled clock edge an update event takes place. The shadow values are loaded, and in the next cycle the first period begins with `data_req` = 1.
- R12: After reset, `pwm_out` and `data_req` are 0, and all compare and reload registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the counter when high; holds the channel idle when low |
| cmp_preload | input | 1 | 1 = compare writes go to the shadow; 0 = compare writes go to the active register |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | WIDTH | Compare write value |
| arr_wr | input | 1 | Reload write strobe |
| arr_wdata | input | WIDTH | Reload write value |
| pwm_out | output | 1 | Pulse output |
| data_req | output | 1 | One-cycle request for the next compare word |

## Verification
On every cycle the assertions check the following:
- The counter's step-or-wrap pattern.
- That the request appears only at count zero.
- The idle state after the enable is dropped.
- The start-up update.
- That the active compare value in preload mode changes only at update events.

Only the bench scenarios can show the widths and lengths of the periods. A scoreboard model fed by the simulated feeder checks them across bursts, including the stopper words, the double writes, the reload changes and compare values above the reload. Directed mid-period writes show the difference between the preload and direct modes at the output.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;

   typedef enum logic [0:0] {
      CMP_DIRECT = 1'b0,
      CMP_SHADOW = 1'b1
   } cmp_mode_e;

   typedef struct packed {
      logic run;
      logic upd;
   } tick_s;

   function automatic bit width_ok(input int w);
      return (w >= 2) && (w <= 64);
   endfunction

endpackage

// File: rtl/pwm_burst_regs.sv
module pwm_burst_regs
   import pwm_burst_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter bit ARR_PRELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cmp_mode_e        mode,
   input  logic             upd,
   input  logic             cmp_wr,
   input  logic [WIDTH-1:0] cmp_wdata,
   input  logic             arr_wr,
   input  logic [WIDTH-1:0] arr_wdata,
   output logic [WIDTH-1:0] cmp_act,
   output logic [WIDTH-1:0] arr_act
);

   localparam logic [WIDTH-1:0] ZERO = '0;

   logic [WIDTH-1:0] cmp_sh;

   initial begin
      if (!width_ok(WIDTH)) $error("pwm_burst_regs: WIDTH out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_sh <= ZERO;
      end else if (cmp_wr) begin
         cmp_sh <= cmp_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_act <= ZERO;
      end else if (cmp_wr && (mode == CMP_DIRECT)) begin
         cmp_act <= cmp_wdata;
      end else if (upd) begin
         cmp_act <= cmp_sh;
      end
   end

   generate
      if (ARR_PRELOAD) begin : g_arr_shadow
         logic [WIDTH-1:0] arr_sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               arr_sh  <= ZERO;
               arr_act <= ZERO;
            end else begin
               if (arr_wr) arr_sh <= arr_wdata;
               if (upd)    arr_act <= arr_sh;
            end
         end
      end else begin : g_arr_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               arr_act <= ZERO;
            end else if (arr_wr) begin
               arr_act <= arr_wdata;
            end
         end
      end
   endgenerate

   // R3: in shadow mode the active compare only moves at an update event
   p_shadow_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == CMP_SHADOW) && !$past(upd) |-> $stable(cmp_act));

endmodule

// File: rtl/pwm_burst_counter.sv
module pwm_burst_counter
   import pwm_burst_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [WIDTH-1:0] arr_act,
   output logic [WIDTH-1:0] cnt,
   output tick_s            tick,
   output logic             req
);

   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   logic run_q;

   initial begin
      if (!width_ok(WIDTH)) $error("pwm_burst_counter: WIDTH out of range");
   end

   // update on start-up or when the count reaches (or passes) the limit
   always_comb begin
      tick.run = run_q;
      tick.upd = enable & (~run_q | (cnt >= arr_act));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         run_q <= 1'b0;
         req   <= 1'b0;
      end else if (!enable) begin
         cnt   <= '0;
         run_q <= 1'b0;
         req   <= 1'b0;
      end else begin
         run_q <= 1'b1;
         req   <= tick.upd;
         cnt   <= tick.upd ? '0 : cnt + ONE;
      end
   end

   // R1: the count either steps by one or returns to zero
   p_step_or_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      run_q && $past(run_q) |-> (cnt == $past(cnt) + ONE) || (cnt == '0));

   // R6: the request marks the first cycle of a period
   p_req_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (cnt == '0) && run_q);

   // R10: a low enable leaves the channel idle on the next cycle
   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !run_q && (cnt == '0) && !req);

   // R11: the first enabled edge starts a period with a request
   p_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      enable && !run_q |=> req && run_q);

endmodule

// File: rtl/pwm_burst_outstage.sv
module pwm_burst_outstage #(
   parameter int WIDTH = 32
) (
   input  logic             run,
   input  logic [WIDTH-1:0] cnt,
   input  logic [WIDTH-1:0] cmp_act,
   output logic             pwm
);

   always_comb begin
      pwm = run & (cnt < cmp_act);
   end

endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen
   import pwm_burst_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter bit ARR_PRELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             cmp_preload,
   input  logic             cmp_wr,
   input  logic [WIDTH-1:0] cmp_wdata,
   input  logic             arr_wr,
   input  logic [WIDTH-1:0] arr_wdata,
   output logic             pwm_out,
   output logic             data_req
);

   logic [WIDTH-1:0] cmp_act;
   logic [WIDTH-1:0] arr_act;
   logic [WIDTH-1:0] cnt;
   tick_s            tick;
   cmp_mode_e        mode;

   assign mode = cmp_preload ? CMP_SHADOW : CMP_DIRECT;

   pwm_burst_regs #(.WIDTH(WIDTH), .ARR_PRELOAD(ARR_PRELOAD)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .upd       (tick.upd),
      .cmp_wr    (cmp_wr),
      .cmp_wdata (cmp_wdata),
      .arr_wr    (arr_wr),
      .arr_wdata (arr_wdata),
      .cmp_act   (cmp_act),
      .arr_act   (arr_act)
   );

   pwm_burst_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .arr_act (arr_act),
      .cnt     (cnt),
      .tick    (tick),
      .req     (data_req)
   );

   pwm_burst_outstage #(.WIDTH(WIDTH)) u_out (
      .run     (tick.run),
      .cnt     (cnt),
      .cmp_act (cmp_act),
      .pwm     (pwm_out)
   );

   // R7: a zero compare word never lets the line go high
   p_zero_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_act == '0) |-> !pwm_out);

endmodule

// File: tb/pwm_burst_gen_bench.sv
module pwm_burst_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        cmp_preload = 1'b1;
   logic        cmp_wr = 1'b0;
   logic [31:0] cmp_wdata = '0;
   logic        arr_wr = 1'b0;
   logic [31:0] arr_wdata = '0;
   logic        pwm_out;
   logic        data_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit mon_on = 1'b0;

   int exp_w[$];
   int exp_len[$];
   string exp_tag[$];
   int words[16];

   always #2.5 clk = ~clk;

   pwm_burst_gen u_pwm_burst_gen (
      .clk(clk), .rst_n(rst_n), .enable(enable), .cmp_preload(cmp_preload),
      .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata), .arr_wr(arr_wr), .arr_wdata(arr_wdata),
      .pwm_out(pwm_out), .data_req(data_req)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // monitor: measures every completed period and compares with the queue
   int  m_len = 0;
   int  m_hi = 0;
   bit  m_low_seen = 1'b0;
   bit  m_in = 1'b0;
   always @(negedge clk) begin
      if (!mon_on || !enable) begin
         m_in = 1'b0;
      end else if (data_req) begin
         if (m_in) begin
            if (exp_w.size() == 0) begin
               check(1'b0, "R6", "unexpected period", m_len, 0);
            end else begin
               int w; int l; string t;
               w = exp_w.pop_front();
               l = exp_len.pop_front();
               t = exp_tag.pop_front();
               check(m_hi == w, t, "high cycles", m_hi, w);
               check(m_len == l, "R1", "period length", m_len, l);
            end
         end
         m_in = 1'b1;
         m_len = 1;
         m_hi = pwm_out ? 1 : 0;
         m_low_seen = !pwm_out;
      end else if (m_in) begin
         m_len++;
         if (pwm_out) begin
            if (m_low_seen) check(1'b0, "R2", "high after low", 1, 0);
            m_hi++;
         end else begin
            m_low_seen = 1'b1;
         end
      end
   end

   // driver: pushes expectations and plays the feeder on each request
   task automatic run_burst(input int arr0, input int n, input int nstop,
                            input int arr_chg_at, input int arr_new, input int dbl_at);
      for (int j = 0; j < n + nstop; j++) begin
         int w; int a; string t;
         w = (j < n) ? words[j] : 0;
         a = (arr_chg_at >= 0 && j > arr_chg_at) ? arr_new : arr0;
         if (j >= n)                   t = "R7";
         else if (j == dbl_at + 1)     t = "R4";
         else if (j == arr_chg_at + 1) t = "R9";
         else if (w > a)               t = "R8";
         else                          t = "R2";
         exp_w.push_back((w < a + 1) ? w : a + 1);
         exp_len.push_back(a + 1);
         exp_tag.push_back(t);
      end
      @(negedge clk);
      cmp_preload = 1'b1;
      arr_wr = 1'b1; arr_wdata = arr0;
      cmp_wr = 1'b1; cmp_wdata = words[0];
      @(negedge clk);
      arr_wr = 1'b0; cmp_wr = 1'b0;
      mon_on = 1'b1;
      enable = 1'b1;
      @(negedge clk);
      check(data_req == 1'b1, "R11", "request after enable", data_req, 1);
      check(pwm_out == (words[0] != 0), "R11", "first period output", pwm_out, words[0] != 0);
      for (int p = 0; p < n + nstop - 1; p++) begin
         if (p > 0) begin
            do @(negedge clk); while (!data_req);
         end
         if (p == dbl_at) begin
            cmp_wr = 1'b1; cmp_wdata = arr0 + 40;
            @(negedge clk);
         end
         cmp_wr = 1'b1;
         cmp_wdata = (p + 1 < n) ? words[p + 1] : 0;
         if (p == arr_chg_at) begin
            arr_wr = 1'b1; arr_wdata = arr_new;
         end
         @(negedge clk);
         cmp_wr = 1'b0; arr_wr = 1'b0;
      end
      while (exp_w.size() != 0) @(negedge clk);
      enable = 1'b0;
      mon_on = 1'b0;
   endtask

   task automatic idle_check();
      bit bad = 1'b0;
      enable = 1'b0;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         cmp_wr = (i == 5);
         cmp_wdata = 50;
         if (pwm_out || data_req) bad = 1'b1;
      end
      cmp_wr = 1'b0;
      check(!bad, "R10", "activity while disabled", bad, 0);
   endtask

   task automatic mid_write(input bit pre);
      @(negedge clk);
      cmp_preload = pre;
      arr_wr = 1'b1; arr_wdata = 19;
      cmp_wr = 1'b1; cmp_wdata = 5;
      @(negedge clk);
      arr_wr = 1'b0; cmp_wr = 1'b0;
      enable = 1'b1;
      @(negedge clk);
      check(data_req == 1'b1, "R6", "request at period start", data_req, 1);
      repeat (10) @(negedge clk);
      check(pwm_out == 1'b0, "R2", "low past compare", pwm_out, 0);
      cmp_wr = 1'b1; cmp_wdata = 15;
      @(negedge clk);
      cmp_wr = 1'b0;
      if (pre)
         check(pwm_out == 1'b0, "R3", "shadow write held", pwm_out, 0);
      else
         check(pwm_out == 1'b1, "R5", "direct write immediate", pwm_out, 1);
      do @(negedge clk); while (!data_req);
      repeat (12) @(negedge clk);
      check(pwm_out == 1'b1, pre ? "R3" : "R5", "new value next period", pwm_out, 1);
      @(negedge clk);
      enable = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "R1", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(pwm_out == 1'b0, "R12", "pwm in reset", pwm_out, 0);
      check(data_req == 1'b0, "R12", "request in reset", data_req, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(pwm_out == 1'b0 && data_req == 1'b0, "R12", "idle after reset",
            {pwm_out, data_req}, 0);

      words[0] = 3; words[1] = 7; words[2] = 0; words[3] = 10;
      words[4] = 15; words[5] = 1; words[6] = 5; words[7] = 2;
      run_burst(9, 8, 2, -1, 0, -1);

      idle_check();

      words[0] = 2; words[1] = 4; words[2] = 6; words[3] = 1;
      run_burst(5, 4, 1, 1, 11, 2);

      mid_write(1'b1);
      mid_write(1'b0);

      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule